// File: doc/BRIEF.md
# UART Transmitter with Sixteenth-Resolution Stop Length

This block sends bytes as asynchronous serial frames. Each frame has one start bit, eight data bits sent least significant bit first, and a stop interval. The whole frame is timed by a one-cycle enable pulse that arrives sixteen times per bit period. The stop interval is not limited to one, one and a half or two whole bits. A 4-bit code picks one of sixteen lengths, counted in sixteenths of a bit. This lets a sender shorten its frames by a few sixteenths and keep pace with a receiver whose clock runs slightly faster than its own, even at full line load.

Bytes come in on a valid/ready handshake. The stop-length code lives in a small register written through a strobe. The code is copied at the moment a byte is accepted, so rewriting it while a frame is on the line only affects frames accepted later. Baud-rate generation, parity and reception are handled elsewhere.

Top module: `uart_fstop_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and the stop code is 7, so a frame sent without any code write has a 16-tick stop interval.
- R2: The line falls for the start bit on the first tick edge at or after acceptance, and it stays low for exactly 16 ticks.
- R3: Eight data bits follow the start bit, bit 0 first. Each bit holds its value for exactly 16 ticks.
- R4: Stop codes 0 to 7 give a stop interval of code+9 ticks, from 9 ticks for code 0 to 16 ticks for code 7.
- R5: Stop codes 8 to 15 give a stop interval of code+17 ticks, from 25 ticks for code 8 to 32 ticks for code 15.
- R6: `in_ready` falls on the clock after a byte is accepted (`in_valid` and `in_ready` both 1 at a rising edge). The line stays high from the end of bit 7 onward. `in_ready` rises on the tick edge that completes S-1 stop ticks, where S is the stop length.
- R7: When the next byte is already waiting as `in_ready` rises, the next start edge falls exactly S ticks after the stop interval began. The line is never high for fewer than S ticks between frames.
- R8: The stop code is captured when a byte is accepted. A write to `cfg_code` during a frame changes only the frames accepted after the write.
- R9: While `in_ready` is 0, `in_valid` and `in_data` are ignored. Exactly one frame is sent per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable, 16 per bit period |
| cfg_we | input | 1 | Write strobe for the stop code |
| cfg_code | input | 4 | Stop-length code to store |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be accepted |
| txd | output | 1 | Serial line, idles high |

## Verification
The bench drives the ends of both halves of the code table (0, 7, 8, 15) plus an interior code. It measures the stop interval in ticks at the `in_ready` rise. A decode that puts the jump at the wrong code, or is off by one sixteenth, shows up as a ready edge one or more ticks out. Frames are also sent back to back with the next byte held waiting. A design that releases ready one tick late stretches the gap to S+1; one that starts early shortens it. The bench rewrites the code while a frame is on the line. A design that reads the live register instead of a captured copy ends that frame with the wrong length. Data bits are checked at both the first and the last tick of each bit. This exposes a shifted bit order or a 15- or 17-tick bit.

// File: rtl/uart_fstop_pkg.sv
package uart_fstop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_START,
    ST_DATA,
    ST_STOP
  } tx_state_e;

  // Lower half of the code space ends at exactly one bit, upper half at two.
  function automatic int unsigned stop_ticks(input int unsigned code,
                                             input int unsigned code_w,
                                             input int unsigned ovs);
    int unsigned half;
    half = 1 << (code_w - 1);
    if (code < half) return ovs - half + 1 + code;
    else             return 2 * ovs - 2 * half + 1 + code;
  endfunction

endpackage

// File: rtl/uart_fstop_cfg.sv
module uart_fstop_cfg #(
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk) begin
    if (rst)        code <= CODE_W'(RST_CODE);
    else if (wr_en) code <= wr_code;
  end

endmodule

// File: rtl/uart_fstop_ser.sv
module uart_fstop_ser
  import uart_fstop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CODE_W = 4,
  parameter int LEN_W  = $clog2(2 * OVS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic [LEN_W-1:0]  stop_len
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state;
  logic [LEN_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              accept;
  logic              bit_end;

  assign accept  = in_valid && in_ready;
  assign bit_end = tick && (cnt == LEN_W'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      in_ready <= 1'b1;
      txd      <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      stop_len <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            shreg    <= in_data;
            stop_len <= LEN_W'(stop_ticks(int'(code), CODE_W, OVS));
            in_ready <= 1'b0;
            cnt      <= '0;
            idx      <= '0;
            if (tick) begin
              txd   <= 1'b0;
              state <= ST_START;
            end else begin
              state <= ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (tick) begin
            txd   <= 1'b0;
            cnt   <= '0;
            state <= ST_START;
          end
        end
        ST_START: begin
          if (bit_end) begin
            cnt   <= '0;
            txd   <= shreg[0];
            state <= ST_DATA;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == IDX_W'(DATA_W - 1)) begin
              txd   <= 1'b1;
              state <= ST_STOP;
            end else begin
              idx   <= idx + 1'b1;
              shreg <= shreg >> 1;
              txd   <= shreg[1];
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == stop_len - LEN_W'(2)) begin
              cnt      <= '0;
              in_ready <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_fstop_tx.sv
module uart_fstop_tx #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);

  localparam int LEN_W = $clog2(2 * OVS + 1);

  logic [CODE_W-1:0] code_q;
  logic [LEN_W-1:0]  stop_len;

  uart_fstop_cfg #(
    .CODE_W  (CODE_W),
    .RST_CODE(RST_CODE)
  ) cfg_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_code(cfg_code),
    .code   (code_q)
  );

  uart_fstop_ser #(
    .DATA_W(DATA_W),
    .OVS   (OVS),
    .CODE_W(CODE_W),
    .LEN_W (LEN_W)
  ) ser_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .code    (code_q),
    .in_valid(in_valid),
    .in_data (in_data),
    .in_ready(in_ready),
    .txd     (txd),
    .stop_len(stop_len)
  );

endmodule

// File: rtl/uart_fstop_tx_chk.sv
module uart_fstop_tx_chk #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             os_tick,
  input logic             in_valid,
  input logic             in_ready,
  input logic             txd,
  input logic [LEN_W-1:0] stop_len
);

  // R1: idle state right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (txd && in_ready));

  // R2, R3: the line only changes on tick edges
  a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(os_tick));

  // R6: ready drops after acceptance
  a_r6_ready_falls_on_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R6: the line is high whenever a byte can be accepted
  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> txd);

  // R6: ready returns only on a tick edge
  a_r6_ready_rises_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(os_tick));

  // R8: the captured stop length does not move during a frame
  a_r8_len_held: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && $past(!in_ready)) |-> $stable(stop_len));

endmodule

bind uart_fstop_tx uart_fstop_tx_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .os_tick (os_tick),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .txd     (txd),
  .stop_len(stop_len)
);

// File: tb/uart_fstop_tx_tb_top.sv
module uart_fstop_tx_tb_top;

  localparam int TP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_code = 4'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_ready;
  logic       txd;

  always #2 clk = ~clk;

  uart_fstop_tx dut_i (
    .clk     (clk),
    .rst     (rst),
    .os_tick (os_tick),
    .cfg_we  (cfg_we),
    .cfg_code(cfg_code),
    .in_valid(in_valid),
    .in_data (in_data),
    .in_ready(in_ready),
    .txd     (txd)
  );

  typedef struct {
    logic [7:0] data;
    int         s;
    bit         b2b;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    bench_code = 7;
  bit    done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected stop length from the code table (R4, R5)
  function automatic int exp_stop(input int c);
    return (c < 8) ? c + 9 : c + 17;
  endfunction

  // Monitor state
  int    tick_n = 0;
  int    tdiv = 0;
  bit    m_busy = 0;
  int    ts = 0;
  int    last_rel = -1;
  int    stop_begin = 0;
  int    prev_s = 0;
  bit    have_prev = 0;
  bit    prev_txd = 1;
  bit    prev_ready = 1;
  item_t cur;

  task automatic mon_step();
    int rel;
    if (!rst && !m_busy && prev_txd && !txd) begin
      if (q.size() == 0) begin
        chk(0, "R9 unexpected frame", 1, 0);
      end else begin
        cur = q.pop_front();
        ts = tick_n;
        last_rel = -1;
        m_busy = 1;
        if (have_prev) begin
          if (cur.b2b) chk(ts - stop_begin == prev_s, "R7 back-to-back gap", ts - stop_begin, prev_s);
          else         chk(ts - stop_begin >= prev_s, "R7 minimum gap", ts - stop_begin, prev_s);
        end
      end
    end
    if (m_busy) begin
      rel = tick_n - ts;
      if (rel != last_rel) begin
        last_rel = rel;
        if (rel == 0 || rel == 15)
          chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
        else if (rel >= 16 && rel < 144 && (rel % 16 == 0 || rel % 16 == 15))
          chk(txd == cur.data[rel/16 - 1], "R3 data bit", int'(txd), int'(cur.data[rel/16 - 1]));
        else if (rel == 144) begin
          stop_begin = tick_n;
          chk(txd == 1'b1, "R6 stop high", int'(txd), 1);
        end
      end
      if (rel > 144 && !in_ready && !txd)
        chk(0, "R6 line low in stop", 0, 1);
      if (!prev_ready && in_ready) begin
        if (rel < 144) chk(0, "R6 early ready", rel, 144);
        else chk(tick_n - stop_begin == cur.s - 1, cur.tag, tick_n - stop_begin, cur.s - 1);
        m_busy = 0;
        prev_s = cur.s;
        have_prev = 1;
      end
    end
    prev_txd = txd;
    prev_ready = in_ready;
  endtask

  // Tick generator and monitor share one ordered process
  always @(negedge clk) begin
    if (os_tick) tick_n++;
    mon_step();
    tdiv = (tdiv == TP - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == 0) && !rst;
  end

  task automatic set_code(input int c);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_code = 4'(c);
    @(negedge clk);
    cfg_we = 1'b0;
    bench_code = c;
  endtask

  // Driver: offers a byte, pushes the expected frame when it is taken
  task automatic send(input logic [7:0] d, input bit b2b, input string tag);
    item_t it;
    in_valid = 1'b1;
    in_data = d;
    while (!in_ready) @(negedge clk);
    it.data = d;
    it.s = exp_stop(bench_code);
    it.b2b = b2b;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'hEE;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    repeat (5) @(negedge clk);

    send(8'hA5, 0, "R1 default stop");
    set_code(0);
    send(8'h3C, 0, "R4 code 0");
    send(8'h81, 1, "R4 R7 code 0 b2b");
    set_code(7);
    send(8'h01, 0, "R4 code 7");
    set_code(8);
    send(8'h5A, 0, "R5 code 8");
    send(8'hFF, 1, "R5 R7 code 8 b2b");
    set_code(15);
    send(8'h00, 0, "R5 code 15");
    send(8'h96, 1, "R5 R7 code 15 b2b");
    set_code(3);
    fork
      send(8'hC3, 0, "R8 frame before write");
      begin
        repeat (60) @(negedge clk);
        set_code(12);
      end
    join
    send(8'h7E, 1, "R8 frame after write");
    send(8'h42, 1, "R9 R7 held valid");

    wait (q.size() == 0 && !m_busy);
    repeat (20) @(negedge clk);
    chk(txd == 1'b1, "R6 idle after frames", int'(txd), 1);
    finish_run();
  end

endmodule